// File: doc/BRIEF.md
# Confidence-Gated Last-Value Result Predictor

This block predicts the result of an instruction from the result it produced the last time it ran. A front-end lookup port takes a PC and returns, in the same cycle, the stored result for that PC and a flag that says whether the prediction may be used. A back-end training port takes the PC of a finished instruction, its computed result and whether a prediction had been handed out for it. The block then adjusts its state and, one cycle later, flags a misprediction.

There are two direct-mapped tables, both indexed by PC word address. The value table holds a valid bit, a partial PC tag and a 64-bit last result per entry, with 4096 entries by default. The confidence table holds a 2-bit saturating counter per entry, with 1024 entries by default. A prediction is offered only when the value entry hits and its counter is at 2 or 3. When the counter is at 3, the stored value is locked against a single wrong result.

Top module: `conf_value_pred`

## Requirements
- R1: After reset every value entry is invalid, so no lookup offers a prediction, and `mispred_o` is low.
- R2: `pred_valid_o` is high only when the value entry at the lookup index is valid, its tag equals the lookup PC's tag, and the confidence counter at the lookup index is 2 or 3. `pred_value_o` is the stored result of that entry.
- R3: An update whose value entry is invalid, or whose tag differs, is a first encounter. It writes the result, sets valid and the tag, and sets the counter to 0.
- R4: An update that hits and whose result equals the stored value increments the counter, which saturates at 3. The stored value is unchanged.
- R5: An update that hits with a different result and a counter of 0, 1 or 2 decrements the counter, which saturates at 0, and writes the new result into the entry.
- R6: An update that hits with a different result and a counter of 3 moves the counter to 2 and keeps the stored value.
- R7: `mispred_o` is high for exactly one cycle, in the cycle after an update with `upd_used_i` high, when the entry missed or the stored value differed from the result. It is low otherwise.
- R8: A tag miss in the value table gives no prediction, whatever the counter value.
- R9: Lookup reads registered table state. An update in the same cycle to the same PC becomes visible to lookup only in the next cycle.
- R10: The value table index is PC bits [13:2], its tag is PC bits [25:14], and the confidence index is PC bits [11:2]. Two PCs that differ by 1024 words therefore share a counter, and a first encounter of one of them clears the counter for the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_pc_i | input | 64 | PC to predict |
| pred_valid_o | output | 1 | Prediction may be used |
| pred_value_o | output | 64 | Predicted result |
| upd_valid_i | input | 1 | Training update strobe |
| upd_pc_i | input | 64 | PC of the finished instruction |
| upd_result_i | input | 64 | Computed result |
| upd_used_i | input | 1 | A prediction had been supplied for this instance |
| mispred_o | output | 1 | One-cycle pulse: supplied prediction was wrong |

## Verification
The bound checker enforces the following rules on every cycle. A mispredict pulse appears only after a used update, and never after a correct one. The cycle after a first encounter or a low-confidence miss shows no prediction for that PC. A locked entry still offers its old value after a wrong result, and a confident match still offers the result. The full counter walk can only be shown by the bench's directed scenarios: saturation at both ends, eviction by a tag conflict, the shared-counter alias, and the one-cycle delay of a same-cycle update.

// File: rtl/cvp_pkg.sv
package cvp_pkg;
  typedef logic [1:0] conf_t;

  localparam conf_t CONF_MIN = 2'd0;
  localparam conf_t CONF_USE = 2'd2;
  localparam conf_t CONF_MAX = 2'd3;

  function automatic conf_t conf_inc(conf_t c);
    return (c == CONF_MAX) ? c : c + 2'd1;
  endfunction

  function automatic conf_t conf_dec(conf_t c);
    return (c == CONF_MIN) ? c : c - 2'd1;
  endfunction

  function automatic logic conf_offers(conf_t c);
    return c >= CONF_USE;
  endfunction
endpackage

// File: rtl/vp_value_table.sv
module vp_value_table #(
  parameter int unsigned ENTRIES = 4096,
  parameter int unsigned TAG_W   = 12,
  parameter int unsigned VAL_W   = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] la_idx_i,
  output logic             la_valid_o,
  output logic [TAG_W-1:0] la_tag_o,
  output logic [VAL_W-1:0] la_val_o,
  input  logic [IDX_W-1:0] tr_idx_i,
  output logic             tr_valid_o,
  output logic [TAG_W-1:0] tr_tag_o,
  output logic [VAL_W-1:0] tr_val_o,
  input  logic             wr_en_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [VAL_W-1:0] wr_val_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [VAL_W-1:0]   val_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (wr_en_i) valid_q[tr_idx_i] <= 1'b1;
  end

  // payload needs no reset: guarded by valid
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[tr_idx_i] <= wr_tag_i;
      val_q[tr_idx_i] <= wr_val_i;
    end
  end

  assign la_valid_o = valid_q[la_idx_i];
  assign la_tag_o   = tag_q[la_idx_i];
  assign la_val_o   = val_q[la_idx_i];
  assign tr_valid_o = valid_q[tr_idx_i];
  assign tr_tag_o   = tag_q[tr_idx_i];
  assign tr_val_o   = val_q[tr_idx_i];
endmodule

// File: rtl/vp_conf_table.sv
module vp_conf_table
  import cvp_pkg::*;
#(
  parameter int unsigned ENTRIES = 1024,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] la_idx_i,
  output conf_t            la_conf_o,
  input  logic [IDX_W-1:0] tr_idx_i,
  output conf_t            tr_conf_o,
  input  logic             wr_en_i,
  input  conf_t            wr_conf_i
);
  conf_t conf_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(ENTRIES); i++) conf_q[i] <= CONF_MIN;
    end else if (wr_en_i) begin
      conf_q[tr_idx_i] <= wr_conf_i;
    end
  end

  assign la_conf_o = conf_q[la_idx_i];
  assign tr_conf_o = conf_q[tr_idx_i];
endmodule

// File: rtl/vp_train_ctrl.sv
module vp_train_ctrl
  import cvp_pkg::*;
#(
  parameter int unsigned TAG_W = 12,
  parameter int unsigned VAL_W = 64
) (
  input  logic             upd_valid_i,
  input  logic             upd_used_i,
  input  logic [TAG_W-1:0] upd_tag_i,
  input  logic [VAL_W-1:0] upd_result_i,
  input  logic             ent_valid_i,
  input  logic [TAG_W-1:0] ent_tag_i,
  input  logic [VAL_W-1:0] ent_val_i,
  input  conf_t            ent_conf_i,
  output logic             hit_o,
  output logic             vt_we_o,
  output logic             ct_we_o,
  output conf_t            ct_next_o,
  output logic             mispred_d_o
);
  logic same_val;

  assign hit_o    = ent_valid_i && (ent_tag_i == upd_tag_i);
  assign same_val = hit_o && (ent_val_i == upd_result_i);

  always_comb begin
    vt_we_o   = 1'b0;
    ct_we_o   = 1'b0;
    ct_next_o = ent_conf_i;
    if (upd_valid_i) begin
      ct_we_o = 1'b1;
      if (!hit_o) begin
        vt_we_o   = 1'b1;
        ct_next_o = CONF_MIN;
      end else if (same_val) begin
        ct_next_o = conf_inc(ent_conf_i);
      end else begin
        ct_next_o = conf_dec(ent_conf_i);
        vt_we_o   = (ent_conf_i != CONF_MAX); // top state locks the value
      end
    end
  end

  assign mispred_d_o = upd_valid_i && upd_used_i && !same_val;
endmodule

// File: rtl/conf_value_pred.sv
module conf_value_pred
  import cvp_pkg::*;
#(
  parameter int unsigned PC_W       = 64,
  parameter int unsigned VAL_W      = 64,
  parameter int unsigned VT_ENTRIES = 4096,
  parameter int unsigned CT_ENTRIES = 1024,
  parameter int unsigned TAG_W      = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  lookup_pc_i,
  output logic             pred_valid_o,
  output logic [VAL_W-1:0] pred_value_o,
  input  logic             upd_valid_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic [VAL_W-1:0] upd_result_i,
  input  logic             upd_used_i,
  output logic             mispred_o
);
  localparam int unsigned WORD_LSB = 2;
  localparam int unsigned VT_IDX_W = $clog2(VT_ENTRIES);
  localparam int unsigned CT_IDX_W = $clog2(CT_ENTRIES);
  localparam int unsigned TAG_LSB  = WORD_LSB + VT_IDX_W;
  localparam int unsigned TAG_MSB  = TAG_LSB + TAG_W - 1;

  logic [VT_IDX_W-1:0] la_vt_idx, tr_vt_idx;
  logic [CT_IDX_W-1:0] la_ct_idx, tr_ct_idx;
  logic [TAG_W-1:0]    la_tag, tr_tag;

  assign la_vt_idx = lookup_pc_i[WORD_LSB +: VT_IDX_W];
  assign tr_vt_idx = upd_pc_i[WORD_LSB +: VT_IDX_W];
  assign la_ct_idx = lookup_pc_i[WORD_LSB +: CT_IDX_W];
  assign tr_ct_idx = upd_pc_i[WORD_LSB +: CT_IDX_W];
  assign la_tag    = lookup_pc_i[TAG_LSB +: TAG_W];
  assign tr_tag    = upd_pc_i[TAG_LSB +: TAG_W];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lookup_pc_i[WORD_LSB-1:0], lookup_pc_i[PC_W-1:TAG_MSB+1],
                            upd_pc_i[WORD_LSB-1:0], upd_pc_i[PC_W-1:TAG_MSB+1]};

  logic             la_valid, tr_valid;
  logic [TAG_W-1:0] la_ent_tag, tr_ent_tag;
  logic [VAL_W-1:0] la_val, tr_val;
  conf_t            la_conf, tr_conf, ct_next;
  logic             vt_we, ct_we, upd_hit, mispred_d;

  vp_value_table #(
    .ENTRIES (VT_ENTRIES),
    .TAG_W   (TAG_W),
    .VAL_W   (VAL_W)
  ) i_vt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .la_idx_i   (la_vt_idx),
    .la_valid_o (la_valid),
    .la_tag_o   (la_ent_tag),
    .la_val_o   (la_val),
    .tr_idx_i   (tr_vt_idx),
    .tr_valid_o (tr_valid),
    .tr_tag_o   (tr_ent_tag),
    .tr_val_o   (tr_val),
    .wr_en_i    (vt_we),
    .wr_tag_i   (tr_tag),
    .wr_val_i   (upd_result_i)
  );

  vp_conf_table #(
    .ENTRIES (CT_ENTRIES)
  ) i_ct (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .la_idx_i  (la_ct_idx),
    .la_conf_o (la_conf),
    .tr_idx_i  (tr_ct_idx),
    .tr_conf_o (tr_conf),
    .wr_en_i   (ct_we),
    .wr_conf_i (ct_next)
  );

  vp_train_ctrl #(
    .TAG_W (TAG_W),
    .VAL_W (VAL_W)
  ) i_train (
    .upd_valid_i  (upd_valid_i),
    .upd_used_i   (upd_used_i),
    .upd_tag_i    (tr_tag),
    .upd_result_i (upd_result_i),
    .ent_valid_i  (tr_valid),
    .ent_tag_i    (tr_ent_tag),
    .ent_val_i    (tr_val),
    .ent_conf_i   (tr_conf),
    .hit_o        (upd_hit),
    .vt_we_o      (vt_we),
    .ct_we_o      (ct_we),
    .ct_next_o    (ct_next),
    .mispred_d_o  (mispred_d)
  );

  assign pred_valid_o = la_valid && (la_ent_tag == la_tag) && conf_offers(la_conf);
  assign pred_value_o = la_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mispred_o <= 1'b0;
    else         mispred_o <= mispred_d;
  end
endmodule

// File: rtl/conf_value_pred_chk.sv
module conf_value_pred_chk #(
  parameter int unsigned PC_W  = 64,
  parameter int unsigned VAL_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PC_W-1:0]  lookup_pc_i,
  input logic             pred_valid_o,
  input logic [VAL_W-1:0] pred_value_o,
  input logic             upd_valid_i,
  input logic [PC_W-1:0]  upd_pc_i,
  input logic [VAL_W-1:0] upd_result_i,
  input logic             upd_used_i,
  input logic             mispred_o,
  input logic             upd_hit,
  input logic [1:0]       upd_conf,
  input logic [VAL_W-1:0] upd_stored
);
  // R1
  mispred_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(mispred_o));

  // R7
  mispred_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispred_o |-> $past(upd_valid_i && upd_used_i));

  // R7
  no_false_mispred_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_hit && upd_stored == upd_result_i) |=> !mispred_o);

  // R3
  fill_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_hit) |=> (lookup_pc_i != $past(upd_pc_i)) || !pred_valid_o);

  // R5
  low_miss_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_hit && upd_conf != 2'd3 && upd_stored != upd_result_i)
    |=> (lookup_pc_i != $past(upd_pc_i)) || !pred_valid_o);

  // R6
  value_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_hit && upd_conf == 2'd3 && upd_stored != upd_result_i)
    |=> (lookup_pc_i != $past(upd_pc_i)) ||
        (pred_valid_o && pred_value_o == $past(upd_stored)));

  // R4
  confident_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_hit && upd_conf >= 2'd2 && upd_stored == upd_result_i)
    |=> (lookup_pc_i != $past(upd_pc_i)) ||
        (pred_valid_o && pred_value_o == $past(upd_result_i)));
endmodule

bind conf_value_pred conf_value_pred_chk #(
  .PC_W  (PC_W),
  .VAL_W (VAL_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lookup_pc_i  (lookup_pc_i),
  .pred_valid_o (pred_valid_o),
  .pred_value_o (pred_value_o),
  .upd_valid_i  (upd_valid_i),
  .upd_pc_i     (upd_pc_i),
  .upd_result_i (upd_result_i),
  .upd_used_i   (upd_used_i),
  .mispred_o    (mispred_o),
  .upd_hit      (upd_hit),
  .upd_conf     (tr_conf),
  .upd_stored   (tr_val)
);

// File: tb/test_conf_value_pred.sv
`timescale 1ns/1ps
module test_conf_value_pred;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] lookup_pc_i = '0;
  logic        pred_valid_o;
  logic [63:0] pred_value_o;
  logic        upd_valid_i = 1'b0;
  logic [63:0] upd_pc_i = '0;
  logic [63:0] upd_result_i = '0;
  logic        upd_used_i = 1'b0;
  logic        mispred_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  conf_value_pred i_conf_value_pred (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lookup_pc_i  (lookup_pc_i),
    .pred_valid_o (pred_valid_o),
    .pred_value_o (pred_value_o),
    .upd_valid_i  (upd_valid_i),
    .upd_pc_i     (upd_pc_i),
    .upd_result_i (upd_result_i),
    .upd_used_i   (upd_used_i),
    .mispred_o    (mispred_o)
  );

  localparam logic [63:0] PC_A = 64'h1000, PC_C = 64'h5000;
  localparam logic [63:0] PC_B = 64'h5010, PC_E = 64'h2008, PC_D = 64'h3008;
  localparam logic [63:0] PC_F = 64'h6020, PC_G = 64'h7030;
  localparam logic [63:0] VX = 64'hDEAD_BEEF_0000_1111, VY = 64'h0123_4567_89AB_CDEF;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // starts and ends at a negedge; mispred_o of this update is visible on return
  task automatic upd(logic [63:0] pc, logic [63:0] v, logic used);
    upd_valid_i = 1'b1; upd_pc_i = pc; upd_result_i = v; upd_used_i = used;
    @(posedge clk_i); @(negedge clk_i);
    upd_valid_i = 1'b0; upd_used_i = 1'b0;
  endtask

  task automatic look(string req, logic [63:0] pc, logic exp_v, logic [63:0] exp_val);
    lookup_pc_i = pc; #0.5;
    check(req, "pred_valid", {63'd0, pred_valid_o}, {63'd0, exp_v});
    if (exp_v) check(req, "pred_value", pred_value_o, exp_val);
  endtask

  task automatic t_reset();
    check("R1", "mispred after reset", {63'd0, mispred_o}, 64'd0);
    look("R1", PC_A, 1'b0, '0);
    look("R1", PC_F, 1'b0, '0);
  endtask

  task automatic t_train();
    upd(PC_A, VX, 1'b0); look("R3", PC_A, 1'b0, '0);       // ctr 0
    upd(PC_A, VX, 1'b0); look("R4", PC_A, 1'b0, '0);       // ctr 1
    upd(PC_A, VX, 1'b0); look("R2", PC_A, 1'b1, VX);       // ctr 2
    upd(PC_A, VX, 1'b1);                                    // ctr 3
    check("R7", "mispred on correct use", {63'd0, mispred_o}, 64'd0);
    look("R4", PC_A, 1'b1, VX);
  endtask

  task automatic t_lock();
    upd(PC_A, VY, 1'b1);                                    // ctr 3 -> 2, value kept
    check("R7", "mispred pulse", {63'd0, mispred_o}, 64'd1);
    look("R6", PC_A, 1'b1, VX);
    @(negedge clk_i);
    check("R7", "mispred single cycle", {63'd0, mispred_o}, 64'd0);
  endtask

  task automatic t_replace();
    upd(PC_A, VY, 1'b1);                                    // ctr 2 -> 1, value Y
    check("R7", "mispred on wrong use", {63'd0, mispred_o}, 64'd1);
    look("R5", PC_A, 1'b0, '0);
    upd(PC_A, VY, 1'b0);                                    // ctr 2
    check("R7", "no mispred when unused", {63'd0, mispred_o}, 64'd0);
    look("R5", PC_A, 1'b1, VY);
    upd(PC_A, VY, 1'b1);                                    // ctr 3
    look("R4", PC_A, 1'b1, VY);
  endtask

  task automatic t_floor();
    upd(PC_B, 64'd1, 1'b0);                                 // fill, ctr 0
    upd(PC_B, 64'd2, 1'b0);                                 // stays 0, value 2
    upd(PC_B, 64'd2, 1'b0);                                 // 1
    look("R5", PC_B, 1'b0, '0);
    upd(PC_B, 64'd2, 1'b0);                                 // 2
    look("R5", PC_B, 1'b1, 64'd2);
  endtask

  task automatic t_tag_miss();
    look("R8", PC_C, 1'b0, '0);                             // A holds index at ctr 3
    look("R8", PC_A, 1'b1, VY);
    upd(PC_C, 64'h55, 1'b0);                                // evicts A, ctr 0
    look("R8", PC_A, 1'b0, '0);
    look("R3", PC_C, 1'b0, '0);
  endtask

  task automatic t_alias();
    upd(PC_E, 64'h77, 1'b0); upd(PC_E, 64'h77, 1'b0); upd(PC_E, 64'h77, 1'b0);
    look("R10", PC_E, 1'b1, 64'h77);
    look("R10", PC_D, 1'b0, '0);                            // shared counter, vt miss
    upd(PC_D, 64'h99, 1'b0);                                // clears shared counter
    look("R10", PC_E, 1'b0, '0);
  endtask

  task automatic t_no_bypass();
    upd(PC_F, 64'h42, 1'b0); upd(PC_F, 64'h42, 1'b0);       // ctr 1
    upd_valid_i = 1'b1; upd_pc_i = PC_F; upd_result_i = 64'h42; upd_used_i = 1'b0;
    lookup_pc_i = PC_F; #0.5;
    check("R9", "same-cycle lookup", {63'd0, pred_valid_o}, 64'd0);
    @(posedge clk_i); @(negedge clk_i);
    upd_valid_i = 1'b0;
    look("R9", PC_F, 1'b1, 64'h42);
  endtask

  task automatic t_miss_used();
    upd(PC_G, 64'h1, 1'b1);
    check("R7", "mispred on used miss", {63'd0, mispred_o}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_train();
    t_lock();
    t_replace();
    t_floor();
    t_tag_miss();
    t_alias();
    t_no_bypass();
    t_miss_used();
    @(negedge clk_i);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule